// File: doc/BRIEF.md
# SPI Flash Command Engine

This block lets software run single serial-flash transactions over an SPI bus through three bus-mapped registers: a control word, a 24-bit flash address and a one-byte data holder. A control write that carries the start bit launches a command. The low byte of the word is the opcode. A four-bit phase code picks what follows the opcode: nothing, a 24-bit address, an address and a data byte, or one byte read back from the flash. The start bit reads back as a busy flag until the transaction is over.

A hold bit in the control word keeps chip select low after a command completes. A later command then continues the same SPI transaction and sends only its data byte, so a page program can stream one byte per register command. Any control write with the start bit clear, such as a write of zero, raises chip select and ends a held transaction. The serial clock is the system clock divided by a parameter, and the bus runs in SPI mode 0.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, and the control, address and data registers read as zero.
- R2: Control bit 31 starts a command when written as 1. It reads back as 1 from the cycle after that write until the transaction ends, and then reads back as 0. SCK toggles only while it is 1.
- R3: Phase code 0 in control bits 11:8 sends only the 8-bit opcode, which sits in control bits 7:0, MSB first. Phase codes 4 to 15 behave the same way.
- R4: Phase code 2 sends the opcode and then the 24-bit address register, MSB first.
- R5: Phase code 3 sends the opcode, the address and then the low 8 bits of the data register. Data register bits above bit 7 are not stored.
- R6: Phase code 1 sends the opcode and then clocks 8 more bits, driving MOSI low during them. The bits sampled from MISO, MSB first, replace the data register.
- R7: SPI mode 0 is used: SCK idles low and MOSI is stable at each rising SCK edge. Chip select falls at least DIV clocks before the first rising edge and rises at least DIV clocks after the last falling edge.
- R8: With control bit 12 set, chip select stays low after the command completes.
- R9: A command launched while chip select is held sends no opcode and no address. Phase 3 sends only its data byte, phase 1 only clocks its 8 read bits, and the other codes send nothing.
- R10: A control write with bit 31 clear, made while idle, raises chip select on the next clock edge.
- R11: While busy, writes to the address and data registers are ignored, and so are control writes, including a new start.
- R12: The registers sit at byte offsets 0x40 (control), 0x44 (address) and 0x48 (data). Control bits 12:0 read back as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench goes after held chip select. A design that repeats the opcode and address on a continued command sends 40 bits where 8 are expected. A design that drops chip select at the end of a held command breaks the page-program stream. It also checks the busy window: a design that takes a write or a second start during a transaction corrupts the address being shifted or sends an extra command, and both show up on the wire or in the register readback. Read commands check that the captured byte lands MSB first in the data register. The chip-select lead and trail margins are measured in clocks, which catches a sequencer that starts SCK as soon as chip select falls.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int unsigned BUS_W     = 32;
  localparam int unsigned START_BIT = 31;
  localparam int unsigned HOLD_BIT  = 12;
  localparam int unsigned CTRL_W    = 13;
  localparam int unsigned ADDR_W    = 24;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned SR_W      = BYTE_W + ADDR_W + BYTE_W;

  localparam logic [3:0] PH_OPC = 4'h0;
  localparam logic [3:0] PH_RD  = 4'h1;
  localparam logic [3:0] PH_ADR = 4'h2;
  localparam logic [3:0] PH_ADW = 4'h3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } seq_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] opcode;
    logic [3:0]        phase;
    logic              hold;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wdata;
  } cmd_t;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int unsigned   AW       = 8,
  parameter logic [AW-1:0] CTRL_OFF = 'h40,
  parameter logic [AW-1:0] ADDR_OFF = 'h44,
  parameter logic [AW-1:0] DATA_OFF = 'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              go,
  output logic              release_cs,
  output logic              busy,
  output cmd_t              cmd
);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              busy_q, busy_d;
  logic              wr_ctrl, wr_addr, wr_data;
  logic              unused_wbits;

  assign wr_ctrl = bus_wr && (bus_addr == CTRL_OFF);
  assign wr_addr = bus_wr && (bus_addr == ADDR_OFF);
  assign wr_data = bus_wr && (bus_addr == DATA_OFF);
  assign unused_wbits = ^bus_wdata[START_BIT-1:ADDR_W];

  always_comb begin
    ctrl_d     = ctrl_q;
    addr_d     = addr_q;
    data_d     = data_q;
    busy_d     = busy_q;
    go         = 1'b0;
    release_cs = 1'b0;
    if (!busy_q) begin
      if (wr_addr) addr_d = bus_wdata[ADDR_W-1:0];
      if (wr_data) data_d = bus_wdata[BYTE_W-1:0];
      if (wr_ctrl) begin
        ctrl_d = bus_wdata[CTRL_W-1:0];
        if (bus_wdata[START_BIT]) begin
          busy_d = 1'b1;
          go     = 1'b1;
        end else begin
          release_cs = 1'b1;
        end
      end
    end else if (done) begin
      busy_d = 1'b0;
      if (ctrl_q[11:8] == PH_RD) data_d = rx_byte;
    end
  end

  always_comb begin
    cmd.opcode = ctrl_d[7:0];
    cmd.phase  = ctrl_d[11:8];
    cmd.hold   = ctrl_d[HOLD_BIT];
    cmd.addr   = addr_q;
    cmd.wdata  = data_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFF) begin
      bus_rdata[CTRL_W-1:0] = ctrl_q;
      bus_rdata[START_BIT]  = busy_q;
    end else if (bus_addr == ADDR_OFF) begin
      bus_rdata[ADDR_W-1:0] = addr_q;
    end else if (bus_addr == DATA_OFF) begin
      bus_rdata[BYTE_W-1:0] = data_q;
    end
  end

  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      busy_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      addr_q <= addr_d;
      data_q <= data_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              release_cs,
  input  cmd_t              cmd,
  input  logic              miso,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned BW   = $clog2(SR_W + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] CNT_RISE = CW'(HALF - 1);
  localparam logic [CW-1:0] CNT_HIGH = CW'(HALF);

  seq_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d, cnt_nx;
  logic [BW-1:0]     bits_q, bits_d;
  logic [SR_W-1:0]   sr_q, sr_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              sck_q, sck_d, cs_n_q, cs_n_d, hold_q, hold_d;
  logic              has_adr, has_wr, has_rd;

  assign has_adr = (cmd.phase == PH_ADR) || (cmd.phase == PH_ADW);
  assign has_wr  = (cmd.phase == PH_ADW);
  assign has_rd  = (cmd.phase == PH_RD);
  assign cnt_nx  = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bits_d  = bits_q;
    sr_d    = sr_q;
    rx_d    = rx_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    hold_d  = hold_q;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (release_cs) cs_n_d = 1'b1;
        if (go) begin
          hold_d = cmd.hold;
          cnt_d  = '0;
          if (!cs_n_q) begin
            sr_d    = {(has_wr ? cmd.wdata : 8'h00), {(SR_W-BYTE_W){1'b0}}};
            bits_d  = (has_wr || has_rd) ? BW'(BYTE_W) : '0;
            state_d = (has_wr || has_rd) ? ST_SHIFT : ST_TRAIL;
          end else begin
            sr_d    = {cmd.opcode, (has_adr ? cmd.addr : 24'h0),
                       (has_wr ? cmd.wdata : 8'h00)};
            bits_d  = BW'(BYTE_W + (has_adr ? ADDR_W : 0) +
                          (has_wr ? BYTE_W : 0) + (has_rd ? BYTE_W : 0));
            cs_n_d  = 1'b0;
            state_d = ST_LEAD;
          end
        end
      end
      ST_LEAD: begin
        cnt_d = cnt_nx;
        if (cnt_q == CNT_LAST) state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        cnt_d = cnt_nx;
        sck_d = (cnt_nx >= CNT_HIGH);
        if (cnt_q == CNT_RISE) rx_d = {rx_q[BYTE_W-2:0], miso};
        if (cnt_q == CNT_LAST) begin
          sr_d   = {sr_q[SR_W-2:0], 1'b0};
          bits_d = bits_q - 1'b1;
          if (bits_q == BW'(1)) state_d = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        cnt_d = cnt_nx;
        if (cnt_q == CNT_LAST) begin
          done    = 1'b1;
          cs_n_d  = !hold_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      sr_q    <= '0;
      rx_q    <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bits_q  <= bits_d;
      sr_q    <= sr_d;
      rx_q    <= rx_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      hold_q  <= hold_d;
    end
  end

  assign sck     = sck_q;
  assign cs_n    = cs_n_q;
  assign mosi    = sr_q[SR_W-1];
  assign rx_byte = rx_q;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned   DIV      = 4,
  parameter int unsigned   AW       = 8,
  parameter logic [AW-1:0] CTRL_OFF = 'h40,
  parameter logic [AW-1:0] ADDR_OFF = 'h44,
  parameter logic [AW-1:0] DATA_OFF = 'h48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);

  cmd_t              cmd;
  logic              go, release_cs, busy, done;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] addr_cur;

  assign addr_cur = cmd.addr;

  spi_cmd_regs #(
    .AW(AW), .CTRL_OFF(CTRL_OFF), .ADDR_OFF(ADDR_OFF), .DATA_OFF(DATA_OFF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
    .rx_byte(rx_byte), .go(go), .release_cs(release_cs), .busy(busy),
    .cmd(cmd)
  );

  spi_cmd_seq #(.DIV(DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .release_cs(release_cs), .cmd(cmd),
    .miso(spi_miso), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .done(done), .rx_byte(rx_byte)
  );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int unsigned   AW       = 8,
  parameter logic [AW-1:0] ADDR_OFF = 'h44
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          spi_sck,
  input logic          spi_cs_n,
  input logic          busy,
  input logic          done,
  input logic [23:0]   addr_cur
);

  p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  p_sck_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> busy);

  p_done_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_cs_rise_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !busy);

  p_addr_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && (bus_addr == ADDR_OFF)) |=> $stable(addr_cur));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.AW(AW), .ADDR_OFF(ADDR_OFF)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .busy(busy), .done(done),
  .addr_cur(addr_cur)
);

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_ADDR = 8'h44;
  localparam logic [7:0] A_DATA = 8'h48;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [23:0] adr;
    logic [31:0] wd;
    logic [7:0]  resp;
    logic [7:0]  nb;
    logic [39:0] cap;
    logic [7:0]  dexp;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h8000_00C7, 24'h000000, 32'h0, 8'h00, 8'd8,  40'hC7,         8'h00, 8'd3}, // R3
    '{32'h8000_07B9, 24'h000000, 32'h0, 8'h00, 8'd8,  40'hB9,         8'h00, 8'd3}, // R3 unlisted code
    '{32'h8000_02D8, 24'h123456, 32'h0, 8'h00, 8'd32, 40'hD8123456,   8'h00, 8'd4}, // R4
    '{32'h8000_0302, 24'hABCDEF, 32'h3A5, 8'h00, 8'd40, 40'h02ABCDEFA5, 8'hA5, 8'd5}, // R5
    '{32'h8000_0105, 24'h000000, 32'h0, 8'hA3, 8'd16, 40'h0500,       8'hA3, 8'd6}, // R6
    '{32'h8000_01AB, 24'h000000, 32'h0, 8'h3C, 8'd16, 40'hAB00,       8'h3C, 8'd6}  // R6
  };

  logic        clk, rst_n, bus_wr, spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  spi_cmd_engine #(.DIV(DIV)) i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc = cyc + 1;

  // flash model
  logic [39:0] cap = '0;
  logic [7:0]  resp = '0;
  int nbits = 0, nb_base = 0, fcnt = 0, fb_base = 0;
  int t_csf = 0, t_first = 0, t_lastf = 0, t_csr = 0;

  always @(negedge spi_cs_n) begin
    nb_base = nbits;
    fb_base = fcnt;
    t_csf   = cyc;
  end
  always @(posedge spi_cs_n) t_csr = cyc;
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (nbits == nb_base) t_first = cyc;
    cap   = {cap[38:0], spi_mosi};
    nbits = nbits + 1;
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    fcnt    = fcnt + 1;
    t_lastf = cyc;
  end
  always_comb begin
    int k;
    k = fcnt - fb_base;
    spi_miso = (k >= 8 && k < 16) ? resp[15-k] : 1'b0;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(A_CTRL, v);
      if (!v[31]) return;
    end
    chk("R2 busy never cleared", 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] mask;
    int base;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", spi_cs_n, 1);
    chk("R1 sck", spi_sck, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_ADDR, v); chk("R1 addr", v, 0);
    rd(A_DATA, v); chk("R1 data", v, 0);

    // table of commands: R3 R4 R5 R6 R7 R2
    for (int n = 0; n < NV; n++) begin
      resp = VECS[n].resp;
      wr(A_ADDR, {8'h0, VECS[n].adr});
      wr(A_DATA, VECS[n].wd);
      wr(A_CTRL, VECS[n].ctrl);
      rd(A_CTRL, v);
      chk("R2 busy set", v[31], 1);
      wait_idle();
      chk($sformatf("R%0d bit count", VECS[n].tag), nbits - nb_base, VECS[n].nb);
      mask = (64'd1 << VECS[n].nb) - 1;
      chk($sformatf("R%0d shifted bits", VECS[n].tag), {24'h0, cap} & mask, VECS[n].cap);
      rd(A_DATA, v);
      chk($sformatf("R%0d data reg", VECS[n].tag), v, {24'h0, VECS[n].dexp});
      chk("R7 cs released", spi_cs_n, 1);
      chk("R7 lead margin", (t_first - t_csf) >= DIV, 1);
      chk("R7 trail margin", (t_csr - t_lastf) >= DIV, 1);
    end

    // R8 R9 R10 R12: held page program stream
    resp = 8'h00;
    wr(A_ADDR, 32'h0000_0100);
    wr(A_DATA, 32'h11);
    wr(A_CTRL, 32'h8000_1302);
    wait_idle();
    base = nb_base;
    chk("R8 cs held low", spi_cs_n, 0);
    chk("R8 first bits", nbits - base, 40);
    rd(A_CTRL, v); chk("R12 ctrl readback", v, 32'h1302);
    rd(A_ADDR, v); chk("R12 addr readback", v, 32'h100);
    wr(A_DATA, 32'h22);
    wr(A_CTRL, 32'h8000_1302);
    wait_idle();
    chk("R9 data-only bits", nbits - base, 48);
    chk("R9 data byte", cap[7:0], 8'h22);
    chk("R9 cs still low", spi_cs_n, 0);
    wr(A_CTRL, 32'h8000_10C7);
    wait_idle();
    chk("R9 no-data held cmd", nbits - base, 48);
    chk("R8 cs low after empty", spi_cs_n, 0);
    wr(A_CTRL, 32'h0);
    chk("R10 cs released", spi_cs_n, 1);
    chk("R10 no bits", nbits - base, 48);

    // R11 writes while busy
    wr(A_ADDR, 32'h000A_0B0C);
    wr(A_DATA, 32'h44);
    wr(A_CTRL, 32'h8000_0302);
    wr(A_ADDR, 32'h0077_7777);
    wr(A_DATA, 32'h99);
    wr(A_CTRL, 32'h8000_00C7);
    wait_idle();
    repeat (60) @(negedge clk);
    chk("R11 one command only", nbits - nb_base, 40);
    chk("R11 shifted bits", {24'h0, cap}, 64'h02_0A0B0C_44);
    rd(A_ADDR, v); chk("R11 addr kept", v, 32'h000A_0B0C);
    rd(A_DATA, v); chk("R11 data kept", v, 32'h44);
    rd(A_CTRL, v); chk("R11 ctrl kept", v, 32'h302);
    chk("R11 cs idle", spi_cs_n, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule